// File: doc/BRIEF.md
# Cache Access Permission Classifier

This block sits on the request path of a cache, beside the tag lookup. For each CPU-side request it takes the request kind, its uncacheable and needs-exclusive qualifiers, and the four state bits of the line the lookup matched. From these it decides whether the request is satisfied locally, must be forwarded untouched to the next level, or needs a fill. For a fill it also chooses the bus command to issue. For a satisfied request it produces the state bits the line must carry afterwards.

Classification is pure combinational logic. Its verdict is captured in one register stage on the cycle the request is valid. The response therefore appears exactly one clock later, framed by `rsp_valid`. Tag storage, data storage and miss tracking live elsewhere. The block only judges and reports.

Request kinds on `req_kind` are 0 read, 1 write, 2 swap, 3 upgrade, 4 writeback and 5 store-conditional. Codes 6 and 7 behave as a read. State bits on `line_state` and `rsp_state` are [3] valid, [2] writable, [1] dirty and [0] prefetched. Bus commands on `rsp_cmd` are 2'b00 read, 2'b01 read-exclusive, 2'b10 upgrade and 2'b11 none.

Top module: `cache_perm_classifier`

## Requirements
- R1: An uncacheable request gives `rsp_fwd`=1, `rsp_hit`=0, `rsp_cmd`=2'b11, `rsp_sc_ok`=0, and `rsp_state` equal to the input state, whatever the line bits are.
- R2: A cacheable request with `req_need_excl`=1 is satisfied only if the line is valid and writable. A request without that flag is satisfied whenever the line is valid (bit 3).
- R3: A cacheable request with `req_need_excl`=1 on a line that is valid but not writable is unsatisfied, gets `rsp_cmd`=2'b10 (upgrade), and leaves the state unchanged.
- R4: A cacheable read, write or swap on an invalid line is unsatisfied, with `rsp_cmd`=2'b01 if exclusive access is needed and 2'b00 otherwise. The state is unchanged.
- R5: A satisfied write (1), swap (2) or store-conditional (5) on a valid line sets the dirty bit (bit 1). A satisfied read or upgrade leaves dirty as it was. Valid and writable are never changed.
- R6: A satisfied request on a valid line whose prefetched bit (bit 0) is set clears that bit and raises `rsp_pf_used` for the single response cycle.
- R7: A cacheable store-conditional on an invalid line is satisfied at once with `rsp_sc_ok`=0 and `rsp_cmd`=2'b11. A store-conditional that hits returns `rsp_sc_ok`=1.
- R8: A cacheable writeback or upgrade on an invalid line gives `rsp_fwd`=1, `rsp_hit`=0 and `rsp_cmd`=2'b11.
- R9: Every response field appears on the clock edge after the cycle in which `req_valid` is 1, with `rsp_valid`=1. In any other cycle, and after reset, `rsp_valid`, `rsp_hit`, `rsp_fwd`, `rsp_sc_ok`, `rsp_pf_used` and `rsp_state` are 0 and `rsp_cmd` is 2'b11.
- R10: In every cycle at most one of `rsp_hit`, `rsp_fwd` and (`rsp_cmd` != 2'b11) is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | Request kind code |
| req_uncacheable | input | 1 | Request bypasses the cache |
| req_need_excl | input | 1 | Request needs a writable copy |
| line_state | input | 4 | Matched line state {valid, writable, dirty, prefetched} |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Request satisfied locally |
| rsp_fwd | output | 1 | Request forwarded unchanged to the next level |
| rsp_cmd | output | 2 | Bus command for a fill, 2'b11 if none |
| rsp_state | output | 4 | Line state after the access |
| rsp_sc_ok | output | 1 | Store-conditional result value |
| rsp_pf_used | output | 1 | A prefetched line was used for the first time |

## Verification
Several properties are checked on every cycle against the inputs one cycle earlier. These cover the following: the uncacheable bypass, the upgrade choice on a read-only line, the immediate failure of a store-conditional on an invalid line, and the prefetch-use pulse with its cleared bit. They also cover the idle values outside a response and the mutual exclusion of hit, forward and fill. Other behaviours depend on the request kind together with the bits it may touch. These are the read versus read-exclusive choice, which kinds set dirty, and writebacks and upgrades forwarded on a miss. Only the bench's scenarios show these, comparing every field against a model in the bench for each kind crossed with each line state, plus a long random run with back-to-back requests.

// File: rtl/cacl_pkg.sv
package cacl_pkg;

  parameter int KIND_W = 3;
  parameter int CMD_W  = 2;

  typedef enum logic [KIND_W-1:0] {
    K_READ  = 3'd0,
    K_WRITE = 3'd1,
    K_SWAP  = 3'd2,
    K_UPG   = 3'd3,
    K_WB    = 3'd4,
    K_SC    = 3'd5,
    K_RSV6  = 3'd6,
    K_RSV7  = 3'd7
  } req_kind_e;

  typedef enum logic [CMD_W-1:0] {
    CMD_READ    = 2'b00,
    CMD_READ_EX = 2'b01,
    CMD_UPGRADE = 2'b10,
    CMD_NONE    = 2'b11
  } bus_cmd_e;

  typedef struct packed {
    logic valid;
    logic writable;
    logic dirty;
    logic prefetched;
  } line_state_t;

  localparam int STATE_W = $bits(line_state_t);

  typedef struct packed {
    logic        hit;
    logic        fwd;
    bus_cmd_e    cmd;
    line_state_t state;
    logic        sc_ok;
    logic        pf_used;
  } verdict_t;

  localparam verdict_t VERDICT_IDLE = '{hit: 1'b0, fwd: 1'b0, cmd: CMD_NONE,
                                        state: '0, sc_ok: 1'b0, pf_used: 1'b0};

endpackage

// File: rtl/cacl_judge.sv
module cacl_judge
  import cacl_pkg::*;
(
  input  req_kind_e   kind,
  input  logic        uncacheable,
  input  logic        need_excl,
  input  line_state_t st,
  output logic        satisfied,
  output logic        line_hit,
  output logic        forward,
  output bus_cmd_e    cmd,
  output logic        sc_ok
);
  logic perm_ok;

  always_comb begin
    perm_ok   = need_excl ? (st.valid & st.writable) : st.valid;
    satisfied = 1'b0;
    line_hit  = 1'b0;
    forward   = 1'b0;
    cmd       = CMD_NONE;
    sc_ok     = 1'b0;
    if (uncacheable) begin
      forward = 1'b1;
    end else if (perm_ok) begin
      satisfied = 1'b1;
      line_hit  = 1'b1;
      sc_ok     = (kind == K_SC);
    end else if (!st.valid && kind == K_SC) begin
      satisfied = 1'b1;
    end else if (!st.valid && (kind == K_WB || kind == K_UPG)) begin
      forward = 1'b1;
    end else if (st.valid) begin
      cmd = CMD_UPGRADE;
    end else begin
      cmd = need_excl ? CMD_READ_EX : CMD_READ;
    end
  end
endmodule

// File: rtl/cacl_state_next.sv
module cacl_state_next
  import cacl_pkg::*;
(
  input  req_kind_e   kind,
  input  logic        line_hit,
  input  line_state_t st,
  output line_state_t st_next,
  output logic        pf_used
);
  logic writes;

  always_comb begin
    writes  = (kind == K_WRITE) || (kind == K_SWAP) || (kind == K_SC);
    st_next = st;
    pf_used = 1'b0;
    if (line_hit) begin
      if (writes) st_next.dirty = 1'b1;
      if (st.prefetched) begin
        st_next.prefetched = 1'b0;
        pf_used            = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cacl_resp_reg.sv
module cacl_resp_reg
  import cacl_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     capture,
  input  verdict_t d,
  output logic     q_valid,
  output verdict_t q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q       <= VERDICT_IDLE;
    end else if (capture) begin
      q_valid <= 1'b1;
      q       <= d;
    end else begin
      q_valid <= 1'b0;
      q       <= VERDICT_IDLE;
    end
  end
endmodule

// File: rtl/cache_perm_classifier.sv
module cache_perm_classifier
  import cacl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [KIND_W-1:0]  req_kind,
  input  logic               req_uncacheable,
  input  logic               req_need_excl,
  input  logic [STATE_W-1:0] line_state,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_fwd,
  output logic [CMD_W-1:0]   rsp_cmd,
  output logic [STATE_W-1:0] rsp_state,
  output logic               rsp_sc_ok,
  output logic               rsp_pf_used
);
  req_kind_e   kind;
  line_state_t st_in;
  line_state_t st_new;
  logic        satisfied, line_hit, forward, sc_ok, pf_used;
  bus_cmd_e    cmd;
  verdict_t    verdict_d, verdict_q;

  assign kind  = req_kind_e'(req_kind);
  assign st_in = line_state_t'(line_state);

  cacl_judge u_judge (
    .kind        (kind),
    .uncacheable (req_uncacheable),
    .need_excl   (req_need_excl),
    .st          (st_in),
    .satisfied   (satisfied),
    .line_hit    (line_hit),
    .forward     (forward),
    .cmd         (cmd),
    .sc_ok       (sc_ok)
  );

  cacl_state_next u_next (
    .kind     (kind),
    .line_hit (line_hit),
    .st       (st_in),
    .st_next  (st_new),
    .pf_used  (pf_used)
  );

  always_comb begin
    verdict_d.hit     = satisfied;
    verdict_d.fwd     = forward;
    verdict_d.cmd     = cmd;
    verdict_d.state   = st_new;
    verdict_d.sc_ok   = sc_ok;
    verdict_d.pf_used = pf_used;
  end

  cacl_resp_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .capture (req_valid),
    .d       (verdict_d),
    .q_valid (rsp_valid),
    .q       (verdict_q)
  );

  assign rsp_hit     = verdict_q.hit;
  assign rsp_fwd     = verdict_q.fwd;
  assign rsp_cmd     = verdict_q.cmd;
  assign rsp_state   = verdict_q.state;
  assign rsp_sc_ok   = verdict_q.sc_ok;
  assign rsp_pf_used = verdict_q.pf_used;
endmodule

// File: rtl/cacl_checker.sv
module cacl_checker (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic [2:0] req_kind,
  input logic       req_uncacheable,
  input logic       req_need_excl,
  input logic [3:0] line_state,
  input logic       rsp_valid,
  input logic       rsp_hit,
  input logic       rsp_fwd,
  input logic [1:0] rsp_cmd,
  input logic [3:0] rsp_state,
  input logic       rsp_sc_ok,
  input logic       rsp_pf_used
);
  assert_bypass_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_uncacheable |=>
      rsp_fwd && !rsp_hit && rsp_cmd == 2'b11 && rsp_state == $past(line_state));

  assert_excl_needs_write_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_hit && $past(req_need_excl) && $past(line_state[3]) |-> $past(line_state[2]));

  assert_upgrade_on_readonly_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_uncacheable && req_need_excl && line_state[3] && !line_state[2] |=>
      !rsp_hit && rsp_cmd == 2'b10 && rsp_state == $past(line_state));

  assert_pf_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_pf_used |-> rsp_hit && !rsp_state[0] && $past(line_state[0]));

  assert_sc_fail_R7: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_uncacheable && req_kind == 3'd5 && !line_state[3] |=>
      rsp_hit && !rsp_sc_ok && rsp_cmd == 2'b11);

  assert_follow_R9: assert property (@(posedge clk) disable iff (rst)
    $past(req_valid) && !$past(rst) |-> rsp_valid);

  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !rsp_hit && !rsp_fwd && rsp_cmd == 2'b11 && !rsp_pf_used && !rsp_sc_ok);

  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_hit, rsp_fwd, rsp_cmd != 2'b11}));
endmodule

bind cache_perm_classifier cacl_checker u_chk (
  .clk             (clk),
  .rst             (rst),
  .req_valid       (req_valid),
  .req_kind        (req_kind),
  .req_uncacheable (req_uncacheable),
  .req_need_excl   (req_need_excl),
  .line_state      (line_state),
  .rsp_valid       (rsp_valid),
  .rsp_hit         (rsp_hit),
  .rsp_fwd         (rsp_fwd),
  .rsp_cmd         (rsp_cmd),
  .rsp_state       (rsp_state),
  .rsp_sc_ok       (rsp_sc_ok),
  .rsp_pf_used     (rsp_pf_used)
);

// File: tb/cache_perm_classifier_test.sv
module cache_perm_classifier_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [2:0] req_kind = '0;
  logic       req_uncacheable = 1'b0;
  logic       req_need_excl = 1'b0;
  logic [3:0] line_state = '0;
  logic       rsp_valid, rsp_hit, rsp_fwd, rsp_sc_ok, rsp_pf_used;
  logic [1:0] rsp_cmd;
  logic [3:0] rsp_state;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  cache_perm_classifier uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_uncacheable(req_uncacheable), .req_need_excl(req_need_excl),
    .line_state(line_state), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_fwd(rsp_fwd), .rsp_cmd(rsp_cmd), .rsp_state(rsp_state),
    .rsp_sc_ok(rsp_sc_ok), .rsp_pf_used(rsp_pf_used)
  );

  // Expected {valid, hit, fwd, cmd[1:0], state[3:0], sc_ok, pf_used}
  function automatic logic [10:0] model(input logic [2:0] k, input logic unc,
                                        input logic ex, input logic [3:0] s);
    logic hit = 0, fwd = 0, sc = 0, pf = 0, ok;
    logic [1:0] cmd = 2'b11;
    logic [3:0] ns = s;
    ok = ex ? (s[3] & s[2]) : s[3];
    if (unc) fwd = 1;
    else if (ok) begin
      hit = 1;
      sc  = (k == 3'd5);
      if (k == 3'd1 || k == 3'd2 || k == 3'd5) ns[1] = 1'b1;
      if (s[0]) begin ns[0] = 1'b0; pf = 1; end
    end else if (!s[3] && k == 3'd5) hit = 1;
    else if (!s[3] && (k == 3'd4 || k == 3'd3)) fwd = 1;
    else if (s[3]) cmd = 2'b10;
    else cmd = ex ? 2'b01 : 2'b00;
    return {1'b1, hit, fwd, cmd, ns, sc, pf};
  endfunction

  function automatic string tag_of(input logic [2:0] k, input logic unc,
                                   input logic ex, input logic [3:0] s);
    if (unc) return "R1";
    if (s[3] && ex && !s[2]) return "R3";
    if (!s[3] && k == 3'd5) return "R7";
    if (!s[3] && (k == 3'd3 || k == 3'd4)) return "R8";
    if (!s[3]) return "R4";
    if (s[0]) return "R6";
    if (k == 3'd1 || k == 3'd2 || k == 3'd5) return "R5";
    return "R2";
  endfunction

  task automatic check(input string tag, input logic [10:0] got, input logic [10:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  function automatic logic [10:0] observed();
    return {rsp_valid, rsp_hit, rsp_fwd, rsp_cmd, rsp_state, rsp_sc_ok, rsp_pf_used};
  endfunction

  // Called at a negedge; drives one request, checks it at the next negedge.
  task automatic send(input logic [2:0] k, input logic unc, input logic ex,
                      input logic [3:0] s);
    req_valid = 1; req_kind = k; req_uncacheable = unc;
    req_need_excl = ex; line_state = s;
    @(negedge clk);
    check(tag_of(k, unc, ex, s), observed(), model(k, unc, ex, s));
    if (rsp_valid !== 1'b1) begin
      n_fail++;
      $display("FAIL R9 rsp_valid got=%b exp=1", rsp_valid);
    end
    n_run++;
  endtask

  task automatic idle_check();
    req_valid = 0;
    @(negedge clk);
    check("R9", observed(), 11'b0_0_0_11_0000_0_0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R9", observed(), 11'b0_0_0_11_0000_0_0);   // reset state
    rst = 0;
    @(negedge clk);
    idle_check();

    // Directed corners
    send(3'd0, 1, 0, 4'b1111);          // R1 uncacheable over a good line
    send(3'd1, 0, 1, 4'b1000);          // R3 write on read-only line
    send(3'd1, 0, 1, 4'b0000);          // R4 read-exclusive fill
    send(3'd0, 0, 0, 4'b0000);          // R4 plain read fill
    send(3'd1, 0, 1, 4'b1100);          // R5 write sets dirty
    send(3'd0, 0, 0, 4'b1001);          // R6 read on prefetched line
    send(3'd2, 0, 1, 4'b1101);          // R5/R6 swap on prefetched writable
    send(3'd5, 0, 1, 4'b0000);          // R7 SC on invalid line fails
    send(3'd5, 0, 1, 4'b1100);          // R7 SC hit succeeds
    send(3'd4, 0, 0, 4'b0000);          // R8 writeback miss forwarded
    send(3'd3, 0, 1, 4'b0010);          // R8 upgrade miss forwarded
    send(3'd3, 0, 1, 4'b1110);          // R2 upgrade hit on writable
    send(3'd0, 0, 0, 4'b1000);          // R2 read hit on read-only
    idle_check();

    // Exhaustive sweep of kind x flags x state, with idle gaps
    for (int k = 0; k < 8; k++)
      for (int f = 0; f < 4; f++)
        for (int s = 0; s < 16; s++) begin
          send(3'(k), f[1], f[0], 4'(s));
          if (s == 15) idle_check();
        end

    // Random back-to-back stream, R10 covered by every comparison
    for (int i = 0; i < 2000; i++) begin
      send(3'($urandom), ($urandom % 8) == 0, 1'($urandom), 4'($urandom));
      if (($urandom % 16) == 0) idle_check();
    end
    idle_check();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule